// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This block gathers up to four banks of 32 level-sensitive interrupt lines (three by default) and presents two requests to a processor. The normal request is `irq_out` and the fast request is `fiq_out`. Each line has a route bit that picks one of the two outputs. It also has a 6-bit priority, where a smaller value is more urgent. Software reaches all state through a 32-bit, word-addressed register port. A write happens on the clock edge while `bus_wr` is high. A read is combinational from `bus_addr`.

Each output is governed by a two-state agreement machine.
- In state ARMED, the output is low. The machine takes the transition FIRE into HELD on a clock edge where three things are true: an unmasked line is pending on that route, the global mask is clear, and no soft reset is written.
- On FIRE, the winning line number is latched as that route's vector.
- In state HELD, the output is high. The machine stays there until software writes the route's re-arm bit, which takes the transition REARM back to ARMED.
- A soft reset (transition CLEAR) forces both machines to ARMED from either state.

Per-bank storage:
- a sampled copy of the lines;
- a pending word;
- a mask word, with plain, set and clear write ports;
- a software-request word, with set and clear write ports;
- per line, a priority and a route bit.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask word reads 0xFFFFFFFF. Both outputs are low. Both vectors read 0. All pending views read 0. The control register reads 0.
- R2: A line that goes from 0 to 1 sets its pending bit on the next clock edge. The raw view (bank offset 0x80) shows the sampled lines one edge after they change.
- R3: When any line of a bank falls, on the next edge that bank's pending word becomes the current lines OR the software-request word.
- R4: Bank offset 0x84 writes the mask. Offset 0x88 clears the written one-bits. Offset 0x8C sets them. The 0x88 and 0x8C aliases read 0.
- R5: Bank offset 0x90 ORs the written value into the software word and into pending, and reads back the software word. Offset 0x94 clears the written one-bits of the software word, sets pending to lines OR the remaining software word, and reads 0.
- R6: Bank offset 0x98 reads pending AND NOT mask AND NOT route. Offset 0x9C reads pending AND NOT mask AND route. Each line register at 0x100 + 0x80*bank + 4*line holds the priority in bits [7:2] and the route in bit 0 (1 = fast output). Bit 1 of a line register reads 0.
- R7: An output rises one edge after an unmasked request for its route is visible in pending, provided its machine is ARMED and the global mask is clear. The output stays high until a control write (0x48) with bit 0 (normal) or bit 1 (fast) set, and it is low right after that write. If a request is still present, it rises again on the following edge.
- R8: At FIRE, the vector latches the requesting line with the smallest priority value. Ties go to the highest global line number (32*bank + line). The vector stays unchanged while HELD. Vectors read at 0x40 (normal) and 0x44 (fast).
- R9: Control bit 2 is a global mask. While it is set, neither output can rise, and it reads back in bit 2. Once it is cleared, pending requests fire on the edge after the write.
- R10: At 0x10, bit 0 is autoidle and reads back. Writing bit 1 returns every register to its R1 state, including autoidle. A line that is still high is captured again as pending one edge later.
- R11: 0x00 reads the REV_ID parameter (default 0x21). 0x14 always reads 1. 0x50 holds a 2-bit value.
- R12: A bank access with bank index (address bits [6:5]) at or above NUM_BANKS reads 0 and changes nothing. So does a line-register access beyond the last bank. Writes to 0x00, 0x14, 0x40, 0x44, 0x80 and 0x98/0x9C are ignored. Unmapped or unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_lines | input | NUM_BANKS*32 | Level interrupt lines, line n of bank b at bit 32*b+n |
| bus_wr | input | 1 | Write strobe, committed on the rising edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench targets each of the following cases:
- **Ties of equal priority across banks.** An arbiter that scanned in the wrong direction would report the lowest line number instead of the highest.
- **Priority change while HELD.** A design that followed the arbiter live would show a changing vector while the output is held.
- **Software-clear while the line is still high.** This must leave the hardware-driven bit pending. A design that simply ANDed the masks would drop it.
- **Global mask release.** This must produce the request one edge later.
- **Soft reset with a line held high.** The line must reappear as pending. A design that kept the old sample would lose it.
- **Out-of-range bank, line-register and read-only accesses.** These are checked by reading back every real bank's registers. An address decoder that wrapped the bank index would corrupt bank 0.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES  = 32;
    localparam int LIW    = $clog2(LINES);
    localparam int PRIO_W = 6;
    localparam int DW     = 32;
    localparam int AW     = 12;

    localparam logic [AW-1:0] A_REV     = 12'h000;
    localparam logic [AW-1:0] A_SYSCFG  = 12'h010;
    localparam logic [AW-1:0] A_STATUS  = 12'h014;
    localparam logic [AW-1:0] A_VEC_IRQ = 12'h040;
    localparam logic [AW-1:0] A_VEC_FIQ = 12'h044;
    localparam logic [AW-1:0] A_CTRL    = 12'h048;
    localparam logic [AW-1:0] A_IDLE    = 12'h050;

    // bank-local word select, address bits [4:2]
    typedef enum logic [2:0] {
        S_RAW  = 3'd0,
        S_MASK = 3'd1,
        S_MCLR = 3'd2,
        S_MSET = 3'd3,
        S_SSET = 3'd4,
        S_SCLR = 3'd5,
        S_PIRQ = 3'd6,
        S_PFIQ = 3'd7
    } bank_sub_e;

    typedef enum logic {
        AGR_ARMED = 1'b0,
        AGR_HELD  = 1'b1
    } agr_state_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [LINES-1:0]        lines_in,
    input  logic                    reg_we,
    input  bank_sub_e               reg_sub,
    input  logic [DW-1:0]           wdata,
    input  logic                    ilr_we,
    input  logic [LIW-1:0]          ilr_line,
    output logic [LINES-1:0]        irq_req,
    output logic [LINES-1:0]        fiq_req,
    output logic [LINES*PRIO_W-1:0] prio_flat,
    output logic [DW-1:0]           reg_rdata,
    output logic [DW-1:0]           ilr_rdata
);
    logic [LINES-1:0]  seen_q, pend_q, mask_q, swi_q, route_q;
    logic [LINES-1:0]  pend_d, mask_d, swi_d;
    logic [LINES-1:0]  rise_v, fall_v;
    logic [PRIO_W-1:0] prio_q [LINES];

    assign rise_v = lines_in & ~seen_q;
    assign fall_v = seen_q & ~lines_in;

    always_comb begin
        pend_d = pend_q | rise_v;
        if (|fall_v) pend_d = lines_in | swi_q;
        mask_d = mask_q;
        swi_d  = swi_q;
        if (reg_we) begin
            case (reg_sub)
                S_MASK: mask_d = wdata;
                S_MCLR: mask_d = mask_q & ~wdata;
                S_MSET: mask_d = mask_q | wdata;
                S_SSET: begin
                    swi_d  = swi_q | wdata;
                    pend_d = pend_d | wdata;
                end
                S_SCLR: begin
                    swi_d  = swi_q & ~wdata;
                    pend_d = lines_in | (swi_q & ~wdata);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            seen_q  <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
            swi_q   <= '0;
            route_q <= '0;
            for (int i = 0; i < LINES; i++) prio_q[i] <= '0;
        end else begin
            seen_q <= lines_in;
            pend_q <= pend_d;
            mask_q <= mask_d;
            swi_q  <= swi_d;
            if (ilr_we) begin
                prio_q[ilr_line]  <= wdata[PRIO_W+1:2];
                route_q[ilr_line] <= wdata[0];
            end
        end
    end

    assign irq_req = pend_q & ~mask_q & ~route_q;
    assign fiq_req = pend_q & ~mask_q & route_q;

    for (genvar i = 0; i < LINES; i++) begin : g_flat
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    always_comb begin
        case (reg_sub)
            S_RAW:   reg_rdata = seen_q;
            S_MASK:  reg_rdata = mask_q;
            S_SSET:  reg_rdata = swi_q;
            S_PIRQ:  reg_rdata = irq_req;
            S_PFIQ:  reg_rdata = fiq_req;
            default: reg_rdata = '0;
        endcase
    end

    assign ilr_rdata = {{(DW-PRIO_W-2){1'b0}}, prio_q[ilr_line], 1'b0, route_q[ilr_line]};

    // R2: a rising line is pending after the next edge
    a_r2_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_v && !clr) |=> ((pend_q & $past(rise_v)) == $past(rise_v)));
    // R3: a falling line rebuilds pending from lines and software word
    a_r3_fall_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_v && !reg_we && !clr) |=> (pend_q == ($past(lines_in) | swi_q)));
    // R4: mask-set alias only adds bits
    a_r4_mask_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sub == S_MSET && !clr) |=> (mask_q == ($past(mask_q) | $past(wdata))));
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int N      = 96,
    parameter int PRIO_W = 6,
    parameter int IW     = 7
) (
    input  logic [N-1:0]        req,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                any,
    output logic [IW-1:0]       win
);
    logic [PRIO_W-1:0] best;

    // smaller value wins; "<=" lets a later (higher) line take a tie
    always_comb begin
        best = '1;
        win  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && prio_flat[i*PRIO_W +: PRIO_W] <= best) begin
                best = prio_flat[i*PRIO_W +: PRIO_W];
                win  = IW'(i);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/intc_agree.sv
module intc_agree
    import intc_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rearm,
    input  logic          req_any,
    input  logic          gmask,
    input  logic [IW-1:0] win,
    output logic          out,
    output logic [IW-1:0] vec
);
    agr_state_e state_q, state_d;
    logic       fire;

    assign fire = (state_q == AGR_ARMED) && req_any && !gmask;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AGR_ARMED: if (fire)  state_d = AGR_HELD;
            AGR_HELD:  if (rearm) state_d = AGR_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= AGR_ARMED;
        else if (clr) state_q <= AGR_ARMED;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec <= '0;
        else if (clr)  vec <= '0;
        else if (fire) vec <= win;
    end

    assign out = (state_q == AGR_HELD);

    // R7: held until re-armed
    a_r7_hold_until_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (out && !rearm && !clr) |=> out);
    // R7: no rise without a request
    a_r7_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!out && !req_any) |=> !out);
    // R9: global mask blocks a rise
    a_r9_gmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!out && gmask) |=> !out);
    // R8: vector frozen while held
    a_r8_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out && !clr) |=> $stable(vec));
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import intc_pkg::*;
#(
    parameter int         NUM_BANKS = 3,
    parameter logic [7:0] REV_ID    = 8'h21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*LINES-1:0] int_lines,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    output logic                       irq_out,
    output logic                       fiq_out
);
    localparam int TOTAL = NUM_BANKS * LINES;
    localparam int VEC_W = $clog2(TOTAL);

    // address decode
    logic          aligned, is_bank, ilr_hit;
    logic [1:0]    bank_sel;
    logic [4:0]    ilr_bank;
    logic [LIW-1:0] ilr_line;
    bank_sub_e     sub;
    logic          ctrl_we, sys_we, idle_we, clr;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign is_bank  = ((bus_addr & 12'hF80) == 12'h080) && aligned;
    assign bank_sel = bus_addr[6:5];
    assign sub      = bank_sub_e'(bus_addr[4:2]);
    assign ilr_bank = bus_addr[11:7] - 5'd2;
    assign ilr_hit  = (bus_addr[11:8] != 4'd0) && aligned && (int'(ilr_bank) < NUM_BANKS);
    assign ilr_line = bus_addr[6:2];

    assign ctrl_we = bus_wr && (bus_addr == A_CTRL);
    assign sys_we  = bus_wr && (bus_addr == A_SYSCFG);
    assign idle_we = bus_wr && (bus_addr == A_IDLE);
    assign clr     = sys_we && bus_wdata[1];

    // global registers
    logic       autoidle, gmask;
    logic [1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            autoidle <= 1'b0;
            idle_q   <= 2'b00;
            gmask    <= 1'b0;
        end else begin
            if (sys_we)  autoidle <= bus_wdata[0];
            if (idle_we) idle_q   <= bus_wdata[1:0];
            if (ctrl_we) gmask    <= bus_wdata[2];
        end
    end

    // banks
    logic [TOTAL-1:0]        irq_all, fiq_all;
    logic [TOTAL*PRIO_W-1:0] prio_all;
    logic [DW-1:0]           bank_rd [NUM_BANKS];
    logic [DW-1:0]           ilr_rd  [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .lines_in  (int_lines[b*LINES +: LINES]),
            .reg_we    (bus_wr && is_bank && (bank_sel == 2'(b))),
            .reg_sub   (sub),
            .wdata     (bus_wdata),
            .ilr_we    (bus_wr && ilr_hit && (ilr_bank == 5'(b))),
            .ilr_line  (ilr_line),
            .irq_req   (irq_all[b*LINES +: LINES]),
            .fiq_req   (fiq_all[b*LINES +: LINES]),
            .prio_flat (prio_all[b*LINES*PRIO_W +: LINES*PRIO_W]),
            .reg_rdata (bank_rd[b]),
            .ilr_rdata (ilr_rd[b])
        );
    end

    // two routes: 0 = normal, 1 = fast
    logic [TOTAL-1:0] req_rt [2];
    logic             any_rt [2];
    logic             out_rt [2];
    logic [VEC_W-1:0] win_rt [2];
    logic [VEC_W-1:0] vec_rt [2];

    assign req_rt[0] = irq_all;
    assign req_rt[1] = fiq_all;

    for (genvar r = 0; r < 2; r++) begin : g_route
        intc_arb #(.N(TOTAL), .PRIO_W(PRIO_W), .IW(VEC_W)) u_arb (
            .req       (req_rt[r]),
            .prio_flat (prio_all),
            .any       (any_rt[r]),
            .win       (win_rt[r])
        );
        intc_agree #(.IW(VEC_W)) u_agree (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .rearm   (ctrl_we && bus_wdata[r]),
            .req_any (any_rt[r]),
            .gmask   (gmask),
            .win     (win_rt[r]),
            .out     (out_rt[r]),
            .vec     (vec_rt[r])
        );
    end

    assign irq_out = out_rt[0];
    assign fiq_out = out_rt[1];

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (is_bank) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (bank_sel == 2'(b)) bus_rdata = bank_rd[b];
        end else if (ilr_hit) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (ilr_bank == 5'(b)) bus_rdata = ilr_rd[b];
        end else begin
            case (bus_addr)
                A_REV:     bus_rdata = DW'(REV_ID);
                A_SYSCFG:  bus_rdata = DW'(autoidle);
                A_STATUS:  bus_rdata = DW'(1);
                A_VEC_IRQ: bus_rdata = DW'(vec_rt[0]);
                A_VEC_FIQ: bus_rdata = DW'(vec_rt[1]);
                A_CTRL:    bus_rdata = DW'({gmask, 2'b00});
                A_IDLE:    bus_rdata = DW'(idle_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R12: a bank index past the last bank reads zero
    a_r12_bad_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bank && int'(bank_sel) >= NUM_BANKS) |-> (bus_rdata == '0));
endmodule

// File: tb/lvl_intc_test.sv
module lvl_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] int_lines = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lvl_intc uut (
        .clk(clk), .rst_n(rst_n), .int_lines(int_lines),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic soft_reset;
        int_lines = '0;
        tick(1);
        wr(12'h010, 32'h2);
        tick(1);
    endtask

    task automatic t_reset;
        chk("R1 irq_out low", 32'(irq_out), 0);
        chk("R1 fiq_out low", 32'(fiq_out), 0);
        rdchk("R1 mask bank0", 12'h084, 32'hFFFF_FFFF);
        rdchk("R1 mask bank1", 12'h0A4, 32'hFFFF_FFFF);
        rdchk("R1 mask bank2", 12'h0C4, 32'hFFFF_FFFF);
        rdchk("R1 irq vector", 12'h040, 0);
        rdchk("R1 pending irq", 12'h098, 0);
        rdchk("R1 control", 12'h048, 0);
        rdchk("R11 revision", 12'h000, 32'h21);
        rdchk("R11 status", 12'h014, 1);
    endtask

    task automatic t_level_irq;
        soft_reset();
        int_lines[5] = 1'b1;
        rdchk("R2 raw view", 12'h080, 32'h20);
        rdchk("R6 masked irq view", 12'h098, 0);
        chk("R7 no rise while masked", 32'(irq_out), 0);
        wr(12'h088, 32'h20);
        chk("R7 rise one edge later", 32'(irq_out), 0);
        tick(1);
        chk("R7 irq_out high", 32'(irq_out), 1);
        rdchk("R4 mask after clear", 12'h084, 32'hFFFF_FFDF);
        rdchk("R4 clear alias reads 0", 12'h088, 0);
        rdchk("R4 set alias reads 0", 12'h08C, 0);
        rdchk("R6 irq view", 12'h098, 32'h20);
        rdchk("R6 fiq view", 12'h09C, 0);
        rdchk("R8 single line vector", 12'h040, 5);
        int_lines[5] = 1'b0;
        rdchk("R3 fall clears pending", 12'h098, 0);
        chk("R7 held after fall", 32'(irq_out), 1);
        wr(12'h048, 32'h1);
        chk("R7 low after rearm", 32'(irq_out), 0);
        tick(2);
        chk("R7 stays low without request", 32'(irq_out), 0);
    endtask

    task automatic t_priority;
        soft_reset();
        wr(12'h18C, 32'h08);  // bank1 line3 prio 2
        wr(12'h21C, 32'h08);  // bank2 line7 prio 2
        wr(12'h124, 32'h14);  // bank0 line9 prio 5
        wr(12'h1D0, 32'h0B);  // bank1 line20
        rdchk("R6 line register bit1 reads 0", 12'h1D0, 32'h09);
        wr(12'h084, 0); wr(12'h0A4, 0); wr(12'h0C4, 0);
        int_lines[9] = 1'b1; int_lines[35] = 1'b1; int_lines[71] = 1'b1;
        tick(2);
        chk("R7 irq up", 32'(irq_out), 1);
        rdchk("R8 tie to highest line", 12'h040, 71);
        wr(12'h21C, 32'h0C);  // line 71 prio 3
        rdchk("R6 priority readback", 12'h21C, 32'h0C);
        rdchk("R8 vector frozen while held", 12'h040, 71);
        wr(12'h048, 32'h1);
        rdchk("R8 lowest value wins", 12'h040, 35);
        wr(12'h18C, 32'h18);  // line 35 prio 6
        wr(12'h048, 32'h1);
        rdchk("R8 new winner after rearm", 12'h040, 71);
        chk("R7 refired", 32'(irq_out), 1);
    endtask

    task automatic t_fiq_gmask;
        soft_reset();
        wr(12'h108, 32'h1);   // bank0 line2 to fast route
        wr(12'h084, 0); wr(12'h0A4, 0);
        wr(12'h048, 32'h4);
        int_lines[2] = 1'b1; int_lines[40] = 1'b1;
        tick(3);
        chk("R9 irq blocked", 32'(irq_out), 0);
        chk("R9 fiq blocked", 32'(fiq_out), 0);
        rdchk("R9 gmask readback", 12'h048, 32'h4);
        rdchk("R6 fiq view", 12'h09C, 32'h4);
        rdchk("R6 irq view excludes fast", 12'h098, 0);
        rdchk("R6 bank1 irq view", 12'h0B8, 32'h100);
        rdchk("R6 bank1 fiq view", 12'h0BC, 0);
        wr(12'h048, 32'h0);
        chk("R9 still low at release", 32'(fiq_out), 0);
        tick(1);
        chk("R9 fiq after release", 32'(fiq_out), 1);
        chk("R9 irq after release", 32'(irq_out), 1);
        rdchk("R8 fast vector", 12'h044, 2);
        rdchk("R8 normal vector", 12'h040, 40);
        wr(12'h048, 32'h2);
        chk("R7 fiq rearmed low", 32'(fiq_out), 0);
        chk("R7 irq unaffected", 32'(irq_out), 1);
        tick(1);
        chk("R7 fiq refires", 32'(fiq_out), 1);
    endtask

    task automatic t_swi;
        soft_reset();
        int_lines[32] = 1'b1;
        tick(1);
        wr(12'h0B0, 32'h100);
        rdchk("R5 software word", 12'h0B0, 32'h100);
        rdchk("R5 masked", 12'h0B8, 0);
        wr(12'h0A8, 32'hFFFF_FFFF);
        rdchk("R5 software and line pending", 12'h0B8, 32'h101);
        chk("R7 irq from software", 32'(irq_out), 1);
        rdchk("R8 tie highest in bank1", 12'h040, 40);
        wr(12'h0B4, 32'h100);
        rdchk("R5 clear keeps line bit", 12'h0B8, 32'h1);
        rdchk("R5 software word cleared", 12'h0B0, 0);
        rdchk("R5 clear alias reads 0", 12'h0B4, 0);
        int_lines[32] = 1'b0;
        rdchk("R3 fall with empty software", 12'h0B8, 0);
        wr(12'h0AC, 32'h1);
        rdchk("R4 mask set", 12'h0A4, 32'h1);
        rdchk("R4 set alias reads 0", 12'h0AC, 0);
    endtask

    task automatic t_bounds;
        soft_reset();
        wr(12'h0E4, 32'h0);
        rdchk("R12 bank3 reads 0", 12'h0E4, 0);
        rdchk("R12 bank0 mask untouched", 12'h084, 32'hFFFF_FFFF);
        rdchk("R12 bank1 mask untouched", 12'h0A4, 32'hFFFF_FFFF);
        rdchk("R12 bank2 mask untouched", 12'h0C4, 32'hFFFF_FFFF);
        wr(12'h0F0, 32'hFFFF_FFFF);
        rdchk("R12 bank0 software untouched", 12'h090, 0);
        rdchk("R12 bank1 software untouched", 12'h0B0, 0);
        rdchk("R12 bank2 software untouched", 12'h0D0, 0);
        wr(12'h280, 32'hFD);
        rdchk("R12 line reg past banks", 12'h280, 0);
        rdchk("R12 bank0 line0 untouched", 12'h100, 0);
        rdchk("R12 bank1 line0 untouched", 12'h180, 0);
        rdchk("R12 bank2 line0 untouched", 12'h200, 0);
        wr(12'h080, 32'hFFFF_FFFF);
        rdchk("R12 raw view read-only", 12'h080, 0);
        wr(12'h000, 32'h0);
        rdchk("R12 revision read-only", 12'h000, 32'h21);
        wr(12'h014, 32'h0);
        rdchk("R12 status read-only", 12'h014, 1);
        wr(12'h040, 32'h5);
        rdchk("R12 vector read-only", 12'h040, 0);
        rdchk("R12 unmapped 0x4C", 12'h04C, 0);
        rdchk("R12 unmapped 0x300", 12'h300, 0);
        rdchk("R12 unaligned", 12'h012, 0);
    endtask

    task automatic t_sysconfig;
        soft_reset();
        wr(12'h010, 32'h1);
        rdchk("R10 autoidle readback", 12'h010, 1);
        wr(12'h050, 32'hF);
        rdchk("R11 idle 2 bits", 12'h050, 3);
        int_lines[4] = 1'b1;
        wr(12'h088, 32'h10);
        tick(1);
        chk("R10 irq before soft reset", 32'(irq_out), 1);
        wr(12'h010, 32'h3);
        chk("R10 irq cleared", 32'(irq_out), 0);
        rdchk("R10 autoidle cleared", 12'h010, 0);
        rdchk("R10 idle cleared", 12'h050, 0);
        rdchk("R10 mask restored", 12'h084, 32'hFFFF_FFFF);
        rdchk("R10 vector cleared", 12'h040, 0);
        rdchk("R10 held line seen", 12'h080, 32'h10);
        wr(12'h088, 32'h10);
        rdchk("R10 held line pending again", 12'h098, 32'h10);
        int_lines = '0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_level_irq();
        t_priority();
        t_fiq_gmask();
        t_swi();
        t_bounds();
        t_sysconfig();
        tick(2);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule